// File: doc/BRIEF.md
# Same-Index Routing Switch Box

This block is the programmable junction that sits where one horizontal and one vertical routing channel cross. Each of its four sides (north, east, south, west) carries `TRACKS` wires. Every wire is split into a separate input and output, so the model is directional and needs no bidirectional pass devices. A signal that arrives on track i of one side can be steered only to track i of the other three sides. There are three programmable switches for each incoming wire, one toward each remaining side. A track never reaches a different index.

Each track output has a 3-bit enable mask. The mask picks which of the other three sides' inputs drive that output. The output is the OR of the enabled inputs, or 0 when none is enabled. The masks sit in a serial shift chain that loads while `cfg_en` is high. The chain's serial output lets several boxes share one configuration stream, so a long route is built by enabling matching switches in successive boxes. A flag goes high whenever any output has two or more sources enabled at once.

Top module: `switch_box`

## Requirements
- R1: While reset is asserted, and after its release before any load, every configuration bit is 0. Because of that all track outputs, `conflict` and `cfg_out` are 0.
- R2: The configuration changes only on a rising clock edge with `cfg_en` high. With `cfg_en` low, `cfg_in` has no effect on routing or on `conflict`.
- R3: On each enabled edge the chain shifts by one bit toward index 0, and `cfg_in` enters at the top index 12*TRACKS-1. After 12*TRACKS enabled edges, the first bit shifted in sits at index 0. Bit index k = 12*t + 3*s + j controls track t, output side s (N=0, E=1, S=2, W=3) and mask bit j. Mask bit j enables the input of side (s+1+j) mod 4.
- R4: Each output bit is the OR of the enabled inputs of the same track. With no enabled input it is 0.
- R5: Output track t depends only on input track t of the other sides. A value driven on one track index never appears on another index.
- R6: `conflict` is 1 exactly when at least one (track, side) mask has two or more bits set.
- R7: `cfg_out` presents configuration bit 0. Two boxes chained through it load from one stream: the first 12*TRACKS bits end in the far box. A route enabled in both boxes carries a value end to end.
- R8: The data path holds no register. An input change reaches the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial configuration output, for the next box |
| n_in | input | TRACKS | North side incoming tracks |
| e_in | input | TRACKS | East side incoming tracks |
| s_in | input | TRACKS | South side incoming tracks |
| w_in | input | TRACKS | West side incoming tracks |
| n_out | output | TRACKS | North side outgoing tracks |
| e_out | output | TRACKS | East side outgoing tracks |
| s_out | output | TRACKS | South side outgoing tracks |
| w_out | output | TRACKS | West side outgoing tracks |
| conflict | output | 1 | Some output has more than one source enabled |

## Verification
On every cycle, the assertions check four things:
- the chain holds its contents when `cfg_en` is low;
- each shift captures `cfg_in` at the top of the chain;
- a track with all inputs at zero keeps all its outputs at zero;
- `conflict` stays constant while no shift happens.

Other behaviours can only be shown by the bench's scenarios. These are:
- the exact bit-to-switch mapping and the OR of several sources;
- index isolation under an all-on configuration;
- the same-cycle combinational response;
- a route that crosses two chained boxes loaded from a single stream.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SIDES          = 4;
  localparam int MASK_W         = SIDES - 1;
  localparam int BITS_PER_TRACK = SIDES * MASK_W;

  // Side codes: 0 north, 1 east, 2 south, 3 west.
  // Mask bit j of output side s selects the input of side (s+1+j) mod 4.
  function automatic int src_of(input int side, input int j);
    return (side + 1 + j) % SIDES;
  endfunction
endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int DEPTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [DEPTH-1:0] cfg
);
  logic [DEPTH-1:0] cfg_q;
  logic [DEPTH-1:0] cfg_shift;

  // next state: new bit enters at the top, oldest bit leaves at index 0
  always_comb begin
    cfg_shift = {ser_in, cfg_q[DEPTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (shift_en) begin
      cfg_q <= cfg_shift;
    end
  end

  assign cfg     = cfg_q;
  assign ser_out = cfg_q[0];

  // R2: contents frozen without shift enable
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(cfg_q));

  // R3: serial input captured at the top index
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> cfg_q[DEPTH-1] == $past(ser_in));
endmodule

// File: rtl/sb_track_xbar.sv
module sb_track_xbar
  import sb_pkg::*;
(
  input  logic [SIDES-1:0]          tin,
  input  logic [BITS_PER_TRACK-1:0] mask,
  output logic [SIDES-1:0]          tout,
  output logic                      clash
);
  logic [SIDES-1:0] side_clash;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int SRC0 = src_of(s, 0);
    localparam int SRC1 = src_of(s, 1);
    localparam int SRC2 = src_of(s, 2);
    logic [MASK_W-1:0] en;
    logic [MASK_W-1:0] cand;

    assign en            = mask[s*MASK_W +: MASK_W];
    assign cand          = {tin[SRC2], tin[SRC1], tin[SRC0]};
    assign tout[s]       = |(en & cand);
    assign side_clash[s] = ($countones(en) > 1);
  end

  assign clash = |side_clash;
endmodule

// File: rtl/switch_box.sv
module switch_box
  import sb_pkg::*;
#(
  parameter int TRACKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  input  logic [TRACKS-1:0] n_in,
  input  logic [TRACKS-1:0] e_in,
  input  logic [TRACKS-1:0] s_in,
  input  logic [TRACKS-1:0] w_in,
  output logic [TRACKS-1:0] n_out,
  output logic [TRACKS-1:0] e_out,
  output logic [TRACKS-1:0] s_out,
  output logic [TRACKS-1:0] w_out,
  output logic              conflict
);
  localparam int CFG_BITS = TRACKS * BITS_PER_TRACK;

  logic [CFG_BITS-1:0] cfg;
  logic [TRACKS-1:0]   track_clash;

  sb_cfg_chain #(.DEPTH(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .ser_in   (cfg_in),
    .ser_out  (cfg_out),
    .cfg      (cfg)
  );

  for (genvar t = 0; t < TRACKS; t++) begin : g_track
    logic [SIDES-1:0] tin;
    logic [SIDES-1:0] tout;

    assign tin = {w_in[t], s_in[t], e_in[t], n_in[t]};

    sb_track_xbar u_xbar (
      .tin   (tin),
      .mask  (cfg[t*BITS_PER_TRACK +: BITS_PER_TRACK]),
      .tout  (tout),
      .clash (track_clash[t])
    );

    assign n_out[t] = tout[0];
    assign e_out[t] = tout[1];
    assign s_out[t] = tout[2];
    assign w_out[t] = tout[3];

    // R5: a quiet track index stays quiet on every side
    p_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tin == '0) |-> ({w_out[t], s_out[t], e_out[t], n_out[t]} == '0));
  end

  assign conflict = |track_clash;

  // R6: flag depends on configuration only, so it cannot move without a shift
  p_conflict_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(conflict));
endmodule

// File: tb/switch_box_test.sv
module switch_box_test;
  localparam int CLK_P  = 10;
  localparam int TR     = 4;
  localparam int NB     = TR * 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_in = 1'b0;
  logic mid_ser, far_ser;
  logic [TR-1:0] a_n = '0, a_e = '0, a_s = '0, a_w = '0;
  logic [TR-1:0] b_n = '0, b_e = '0, b_s = '0;
  logic [TR-1:0] an_o, ae_o, as_o, aw_o, bn_o, be_o, bs_o, bw_o;
  logic a_cf, b_cf;
  logic [NB-1:0] cfg_a = '0, cfg_b = '0;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  switch_box #(.TRACKS(TR)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(mid_ser),
    .n_in(a_n), .e_in(a_e), .s_in(a_s), .w_in(a_w),
    .n_out(an_o), .e_out(ae_o), .s_out(as_o), .w_out(aw_o), .conflict(a_cf));

  // far box: its west side is fed by the near box's east side
  switch_box #(.TRACKS(TR)) u_far (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(mid_ser), .cfg_out(far_ser),
    .n_in(b_n), .e_in(b_e), .s_in(b_s), .w_in(ae_o),
    .n_out(bn_o), .e_out(be_o), .s_out(bs_o), .w_out(bw_o), .conflict(b_cf));

  task automatic chk(input string req, input logic [TR-1:0] act, input logic [TR-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // bit position of the switch from side src to output side on track t (R3)
  function automatic int bidx(input int t, input int side, input int src);
    return t * 12 + side * 3 + ((src - side + 3) % 4);
  endfunction

  function automatic logic [TR-1:0] mdl(input logic [NB-1:0] c,
      input logic [TR-1:0] n, input logic [TR-1:0] e, input logic [TR-1:0] s,
      input logic [TR-1:0] w, input int side);
    logic [TR-1:0] ins [4];
    logic [TR-1:0] r;
    ins[0] = n; ins[1] = e; ins[2] = s; ins[3] = w;
    r = '0;
    for (int t = 0; t < TR; t++)
      for (int src = 0; src < 4; src++)
        if (src != side && c[bidx(t, side, src)]) r[t] = r[t] | ins[src][t];
    return r;
  endfunction

  function automatic logic mdl_cf(input logic [NB-1:0] c);
    logic f;
    f = 1'b0;
    for (int g = 0; g < TR * 4; g++)
      if ($countones(c[g*3 +: 3]) > 1) f = 1'b1;
    return f;
  endfunction

  task automatic check_all(input string req);
    logic [TR-1:0] exp_ae;
    exp_ae = mdl(cfg_a, a_n, a_e, a_s, a_w, 1);
    chk(req, an_o, mdl(cfg_a, a_n, a_e, a_s, a_w, 0));
    chk(req, ae_o, exp_ae);
    chk(req, as_o, mdl(cfg_a, a_n, a_e, a_s, a_w, 2));
    chk(req, aw_o, mdl(cfg_a, a_n, a_e, a_s, a_w, 3));
    chk(req, bn_o, mdl(cfg_b, b_n, b_e, b_s, exp_ae, 0));
    chk(req, be_o, mdl(cfg_b, b_n, b_e, b_s, exp_ae, 1));
    chk(req, bs_o, mdl(cfg_b, b_n, b_e, b_s, exp_ae, 2));
    chk(req, bw_o, mdl(cfg_b, b_n, b_e, b_s, exp_ae, 3));
    chk({req, " conflict"}, {3'b0, a_cf}, {3'b0, mdl_cf(cfg_a)});
    chk({req, " conflict"}, {3'b0, b_cf}, {3'b0, mdl_cf(cfg_b)});
  endtask

  // stream far-box bits first, then near-box bits (R7)
  task automatic load();
    for (int k = 0; k < 2 * NB; k++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = (k < NB) ? cfg_b[k] : cfg_a[k - NB];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    #1;
  endtask

  task automatic drive(input logic [TR-1:0] n, input logic [TR-1:0] e,
                       input logic [TR-1:0] s, input logic [TR-1:0] w);
    a_n = n; a_e = e; a_s = s; a_w = w;
    #1;
  endtask

  task automatic t_reset();
    drive(4'hF, 4'hF, 4'hF, 4'hF);
    check_all("R1 reset");
    chk("R1 cfg_out", {3'b0, mid_ser}, 4'b0);
    chk("R1 far cfg_out", {3'b0, far_ser}, 4'b0);
    drive('0, '0, '0, '0);
  endtask

  task automatic t_single();
    cfg_a = '0; cfg_b = '0;
    cfg_a[bidx(2, 1, 3)] = 1'b1;
    load();
    drive('0, '0, '0, 4'b0100);
    chk("R3 west to east track2", ae_o, 4'b0100);
    check_all("R3 single route");
    drive('0, '0, '0, 4'b1011);
    chk("R5 unrouted tracks", ae_o, 4'b0000);
    check_all("R4 unrouted");
  endtask

  task automatic t_comb();
    drive('0, '0, '0, 4'b0100);
    @(posedge clk);
    #2;
    a_w = 4'b0000;
    #1;
    chk("R8 fall without edge", ae_o, 4'b0000);
    a_w = 4'b0100;
    #1;
    chk("R8 rise without edge", ae_o, 4'b0100);
  endtask

  task automatic t_or();
    cfg_a = '0; cfg_b = '0;
    cfg_a[bidx(1, 1, 0)] = 1'b1;
    cfg_a[bidx(1, 1, 2)] = 1'b1;
    load();
    chk("R6 conflict raised", {3'b0, a_cf}, 4'b0001);
    drive(4'b0010, '0, '0, '0);
    chk("R4 north only", ae_o, 4'b0010);
    drive('0, '0, 4'b0010, '0);
    chk("R4 south only", ae_o, 4'b0010);
    drive(4'b0010, '0, 4'b0010, '0);
    chk("R4 both", ae_o, 4'b0010);
    drive('0, '0, '0, '0);
    chk("R4 none", ae_o, 4'b0000);
    check_all("R4 or route");
  endtask

  task automatic t_chain();
    cfg_a = '0; cfg_b = '0;
    cfg_a[bidx(3, 1, 3)] = 1'b1;
    cfg_a[0] = 1'b1;
    cfg_b[bidx(3, 1, 3)] = 1'b1;
    cfg_b[bidx(3, 2, 3)] = 1'b1;
    load();
    chk("R7 near cfg_out", {3'b0, mid_ser}, {3'b0, cfg_a[0]});
    chk("R7 far cfg_out", {3'b0, far_ser}, {3'b0, cfg_b[0]});
    drive('0, '0, '0, 4'b1000);
    chk("R7 end to end east", be_o, 4'b1000);
    chk("R7 end to end south", bs_o, 4'b1000);
    chk("R7 far north quiet", bn_o, 4'b0000);
    check_all("R7 chain");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_in = k[0];
    end
    @(negedge clk);
    cfg_in = 1'b0;
    #1;
    check_all("R2 hold without enable");
  endtask

  task automatic t_isolate();
    cfg_a = '1; cfg_b = '1;
    load();
    for (int t = 0; t < TR; t++)
      for (int s = 0; s < 4; s++) begin
        logic [TR-1:0] v;
        v = '0;
        v[t] = 1'b1;
        drive(s == 0 ? v : '0, s == 1 ? v : '0, s == 2 ? v : '0, s == 3 ? v : '0);
        check_all("R5 isolation");
        chk("R5 north index", an_o & ~v, 4'b0);
        chk("R5 east index", ae_o & ~v, 4'b0);
      end
    drive('0, '0, '0, '0);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_single();
    t_comb();
    t_or();
    t_chain();
    t_hold();
    t_isolate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule